// File: doc/BRIEF.md
# SIMD Fixed-Point Vector Multiplier

This block multiplies two 128-bit operand vectors lane by lane as signed fixed-point numbers. A mode input selects sixteen 8-bit lanes or eight 16-bit lanes. Each lane has its own multiplier and keeps the full-precision product. The product is shifted right by a programmable amount. It is then rounded with one of eight rounding modes and clamped to the signed range of the lane. The lane results are packed back into one 128-bit word, which appears one cycle after the operands with a valid strobe.

A small configuration register holds the shift amount, the rounding mode and a saturation-recording enable. Reading the same register returns those settings together with two sticky status flags. One flag records saturation. The other records an inexact result in the "unnecessary" rounding mode. Both flags are set by any lane of any operation and stay set until the register is read.

Top module: `simd_fxmul`

## Requirements
- R1: With `mode16`=0 the operands are sixteen signed 8-bit lanes; with `mode16`=1 they are eight signed 16-bit lanes. Lane i sits at bits [W*i+W-1 : W*i] of `opa`, `opb` and `result`, and every lane is computed independently of the others.
- R2: `out_valid` rises exactly one cycle after `in_valid` is sampled high and is low otherwise. `result` is loaded in that same cycle.
- R3: Each lane's full product is arithmetically shifted right by the shift field, config bits [5:0]. The whole range 0 to 63 is used. A shift of 0 returns the product unchanged.
- R4: The rounding field is config bits [8:6]. Code 0 rounds toward minus infinity, 1 toward plus infinity, 2 away from zero, and 3 toward zero.
- R5: Codes 4, 5 and 6 round to the nearest value. On an exact tie, 4 goes away from zero, 5 goes toward zero, and 6 goes to the even neighbour.
- R6: Code 7 returns the floor result. It sets the inexact flag, `cfg_rdata[11]`, when any lane discarded a nonzero bit.
- R7: A lane result outside the signed lane range is clamped: to -128..127 for 8-bit lanes and to -32768..32767 for 16-bit lanes.
- R8: The saturation flag, `cfg_rdata[10]`, is set by a clamped lane only while the enable bit, config bit [9], is 1. Clamping takes place whatever the enable says.
- R9: Both flags are sticky across operations. A cycle with `cfg_rd` high clears them on the next edge, unless an operation in that same cycle sets them again.
- R10: After reset the config and flags read as zero. `cfg_wr` loads bits [9:0] on the next edge, so the new settings apply to operations presented in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the config register |
| cfg_wdata | input | 10 | {sat_en, round[2:0], shift[5:0]} |
| cfg_rd | input | 1 | Read strobe; clears the status flags |
| cfg_rdata | output | 12 | {inexact, sat, sat_en, round, shift} |
| in_valid | input | 1 | Operands valid |
| mode16 | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| opa | input | 128 | Operand vector A |
| opb | input | 128 | Operand vector B |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Packed lane results |

## Verification
Several stimulus sets are used, each to tell one mechanism apart from the others:
- The same operand bits are tried in both lane modes, which separates the lane split from the arithmetic.
- Products that land exactly half-way, or a little below or above half-way, for positive and negative signs, separate the eight rounding codes from one another.
- Extreme operands such as -128 times -128, and shifts of 0 and 63, reach the clamp and the edges of the shift range.
- Operations with the saturation enable on and off, mixed with register reads, separate the recording of events from the clamping itself and show when the sticky flags clear.
- A long run of random operands and settings is compared against an independent arithmetic model.

// File: rtl/simd_fxmul.sv
module simd_fxmul #(
  parameter int DW  = 128,
  parameter int SHW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [SHW+3:0]  cfg_wdata,
  input  logic            cfg_rd,
  output logic [SHW+5:0]  cfg_rdata,
  input  logic            in_valid,
  input  logic            mode16,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic            out_valid,
  output logic [DW-1:0]   result
);
  localparam int N8  = DW / 8;
  localparam int N16 = DW / 16;
  localparam int CW  = SHW + 4;

  logic [CW-1:0]  cfg;
  logic           sat_q, inx_q;
  logic [DW-1:0]  res8, res16;
  logic           s8, x8, s16, x16;

  wire [SHW-1:0] sh     = cfg[SHW-1:0];
  wire [2:0]     rm     = cfg[SHW+2:SHW];
  wire           sat_en = cfg[SHW+3];

  assign cfg_rdata = {inx_q, sat_q, cfg};

  // returns {saturated, inexact, value[15:0]}
  function automatic logic [17:0] lane_op(input logic signed [31:0] p,
                                          input logic [SHW-1:0] s,
                                          input logic [2:0] r,
                                          input logic wide);
    logic signed [63:0] px, q, v, hi, lo;
    logic [63:0] mask, rem, half;
    logic neg, nz, gt, tie, inc, sat;
    logic [15:0] o;
    px   = 64'(p);
    q    = px >>> s;
    mask = (64'd1 << s) - 64'd1;
    rem  = px & mask;
    half = (s == '0) ? 64'd0 : (64'd1 << (s - 1'b1));
    neg  = p[31];
    nz   = rem != 64'd0;
    gt   = rem > half;
    tie  = nz && (rem == half);
    case (r)
      3'd1:    inc = nz;
      3'd2:    inc = nz & ~neg;
      3'd3:    inc = nz & neg;
      3'd4:    inc = gt | (tie & ~neg);
      3'd5:    inc = gt | (tie & neg);
      3'd6:    inc = gt | (tie & q[0]);
      default: inc = 1'b0;
    endcase
    v   = q + $signed({63'd0, inc});
    hi  = wide ? 64'sd32767 : 64'sd127;
    lo  = wide ? -64'sd32768 : -64'sd128;
    sat = (v > hi) || (v < lo);
    o   = (v > hi) ? hi[15:0] : (v < lo) ? lo[15:0] : v[15:0];
    return {sat, (r == 3'd7) & nz, o};
  endfunction

  always_comb begin
    logic [17:0] t;
    res8 = '0; res16 = '0;
    s8 = 1'b0; x8 = 1'b0; s16 = 1'b0; x16 = 1'b0;
    for (int i = 0; i < N8; i++) begin
      t = lane_op(32'($signed(opa[8*i +: 8])) * 32'($signed(opb[8*i +: 8])), sh, rm, 1'b0);
      res8[8*i +: 8] = t[7:0];
      s8 = s8 | t[17];
      x8 = x8 | t[16];
    end
    for (int j = 0; j < N16; j++) begin
      t = lane_op(32'($signed(opa[16*j +: 16])) * 32'($signed(opb[16*j +: 16])), sh, rm, 1'b1);
      res16[16*j +: 16] = t[15:0];
      s16 = s16 | t[17];
      x16 = x16 | t[16];
    end
  end

  wire any_sat = mode16 ? s16 : s8;
  wire any_inx = mode16 ? x16 : x8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      sat_q     <= 1'b0;
      inx_q     <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= mode16 ? res16 : res8;
      if (cfg_wr) cfg <= cfg_wdata;
      sat_q <= (sat_q & ~cfg_rd) | (in_valid & sat_en & any_sat);
      inx_q <= (inx_q & ~cfg_rd) | (in_valid & any_inx);
    end
  end
endmodule

// File: rtl/simd_fxmul_chk.sv
module simd_fxmul_chk #(
  parameter int SHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic           cfg_rd,
  input logic           in_valid,
  input logic           out_valid,
  input logic [SHW+5:0] cfg_rdata
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_inexact_needs_mode7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[SHW+5]) |-> $past(in_valid && cfg_rdata[SHW+2:SHW] == 3'd7));
  a_r8_sat_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[SHW+4]) |-> $past(in_valid && cfg_rdata[SHW+3]));
  a_r9_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[SHW+4] && !cfg_rd) |=> cfg_rdata[SHW+4]);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !in_valid) |=> (cfg_rdata[SHW+5:SHW+4] == 2'b00));
  a_r10_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata[SHW+3:0]));
endmodule

bind simd_fxmul simd_fxmul_chk #(.SHW(SHW)) u_chk (.*);

// File: tb/simd_fxmul_tb.sv
module simd_fxmul_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0, cfg_rd = 1'b0, in_valid = 1'b0, mode16 = 1'b0;
  logic [9:0]   cfg_wdata = '0;
  logic [11:0]  cfg_rdata;
  logic [127:0] opa = '0, opb = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [127:0] expq[$];
  string        tagq[$];
  int  c_sh = 0, c_rm = 0;
  bit  c_en = 0, e_sat = 0, e_inx = 0;

  always #10 clk = ~clk;

  simd_fxmul u_dut (.*);

  function automatic longint lane_model(longint p, int sh, int rm, bit w16,
                                        output bit s, output bit x);
    longint q, d, r, v, hi, lo;
    bit exact, gt, tie, neg, inc;
    neg = p < 0;
    if (sh >= 40) begin
      q = neg ? -1 : 0; exact = (p == 0); gt = neg; tie = 0;
    end else begin
      d = longint'(1) << sh;
      q = p / d;
      if ((p % d) != 0 && neg) q = q - 1;
      r = p - q * d;
      exact = (r == 0); gt = (2 * r > d); tie = (r != 0) && (2 * r == d);
    end
    case (rm)
      1: inc = !exact;
      2: inc = !exact && !neg;
      3: inc = !exact && neg;
      4: inc = gt || (tie && !neg);
      5: inc = gt || (tie && neg);
      6: inc = gt || (tie && q[0]);
      default: inc = 0;
    endcase
    v = q + longint'(inc);
    hi = w16 ? 32767 : 127;
    lo = w16 ? -32768 : -128;
    s = (v > hi) || (v < lo);
    x = (rm == 7) && !exact;
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return v;
  endfunction

  task automatic op(input bit m16, input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [127:0] e = '0;
    bit s, x, sa = 0, xa = 0;
    longint v;
    if (m16) begin
      for (int i = 0; i < 8; i++) begin
        v = lane_model(longint'($signed(a[16*i +: 16])) * longint'($signed(b[16*i +: 16])),
                       c_sh, c_rm, 1, s, x);
        e[16*i +: 16] = v[15:0]; sa |= s; xa |= x;
      end
    end else begin
      for (int i = 0; i < 16; i++) begin
        v = lane_model(longint'($signed(a[8*i +: 8])) * longint'($signed(b[8*i +: 8])),
                       c_sh, c_rm, 0, s, x);
        e[8*i +: 8] = v[7:0]; sa |= s; xa |= x;
      end
    end
    expq.push_back(e); tagq.push_back(tag);
    if (sa && c_en) e_sat = 1;
    if (xa) e_inx = 1;
    @(posedge clk); #1;
    in_valid = 1; mode16 = m16; opa = a; opb = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; in_valid = 0;
    end
  endtask

  task automatic wcfg(input bit en, input int rm, input int sh);
    @(posedge clk); #1;
    in_valid = 0; cfg_wr = 1; cfg_wdata = {en, 3'(rm), 6'(sh)};
    @(posedge clk); #1; cfg_wr = 0;
    c_en = en; c_rm = rm; c_sh = sh;
  endtask

  task automatic rdchk(input string tag);
    logic [11:0] exp, got;
    idle(2);
    @(posedge clk); #1; cfg_rd = 1;
    #5; got = cfg_rdata;
    exp = {e_inx, e_sat, c_en, 3'(c_rm), 6'(c_sh)};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cfg_rdata actual %h expected %h", tag, got, exp);
    end
    @(posedge clk); #1; cfg_rd = 0;
    e_sat = 0; e_inx = 0;
  endtask

  function automatic logic [127:0] r8(input logic [7:0] v);
    return {16{v}};
  endfunction
  function automatic logic [127:0] r16(input logic [15:0] v);
    return {8{v}};
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2 out_valid with no pending op actual 1 expected 0");
      end else begin
        logic [127:0] e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        if (result !== e) begin
          errors++;
          $display("FAIL %s result actual %h expected %h", t, result, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    #2;
    checks++;
    if (out_valid !== 0 || cfg_rdata !== 12'h000) begin
      errors++;
      $display("FAIL R10 reset state actual %b/%h expected 0/000", out_valid, cfg_rdata);
    end

    // R1 lane split, exact products
    wcfg(1, 0, 0);
    op(0, r8(8'h05) ^ {120'd0, 8'h7c}, r8(8'hfd), "R1 8-bit lanes");
    op(1, r16(16'h0305), r16(16'h00fd), "R1 16-bit lanes");
    op(0, {8'h80, 112'd0, 8'h7f}, {8'h01, 112'd0, 8'h01}, "R1 lane independence");
    // R3 shift extremes
    wcfg(1, 0, 63);
    op(1, r16(16'hffff), r16(16'h0001), "R3 shift 63 negative");
    op(1, r16(16'h7fff), r16(16'h7fff), "R3 shift 63 positive");
    wcfg(1, 0, 4);
    op(1, r16(16'h1234), r16(16'h0110), "R3 shift 4");
    // R4 directed modes on -3.5
    for (int m = 0; m < 4; m++) begin
      wcfg(1, m, 1);
      op(1, r16(16'hfff9), r16(16'h0001), "R4 directed rounding -3.5");
      op(0, r8(8'h07), r8(8'h01), "R4 directed rounding 3.5");
    end
    // R5 ties
    for (int m = 4; m < 7; m++) begin
      wcfg(1, m, 1);
      op(1, r16(16'h0005), r16(16'h0001), "R5 tie 2.5");
      op(1, r16(16'h0007), r16(16'h0001), "R5 tie 3.5");
      op(0, r8(8'hfb), r8(8'h01), "R5 tie -2.5");
      wcfg(1, m, 3);
      op(0, r8(8'h0d), r8(8'h01), "R5 non-tie 1.625");
    end
    rdchk("R9 flags after rounding set");
    // R6 inexact
    wcfg(0, 7, 2);
    op(1, r16(16'h0008), r16(16'h0003), "R6 exact in mode 7");
    rdchk("R6 exact product no inexact");
    op(1, r16(16'h0009), r16(16'h0003), "R6 inexact in mode 7");
    rdchk("R6 inexact flag set");
    // R7/R8 saturation
    wcfg(0, 0, 0);
    op(0, r8(8'h80), r8(8'h80), "R7 clamp high 8-bit");
    rdchk("R8 sat disabled no flag");
    wcfg(1, 0, 0);
    op(0, r8(8'h80), r8(8'h7f), "R7 clamp low 8-bit");
    op(1, r16(16'h8000), r16(16'h8000), "R7 clamp high 16-bit");
    op(0, r8(8'h01), r8(8'h01), "R9 no-event op keeps sticky");
    rdchk("R8 sat flag set");
    rdchk("R9 flags cleared by read");
    // R10 config applies only later
    @(posedge clk); #1;
    in_valid = 1; mode16 = 1; opa = r16(16'h0011); opb = r16(16'h0001);
    cfg_wr = 1; cfg_wdata = {1'b1, 3'd0, 6'd4};
    expq.push_back(r16(16'h0011)); tagq.push_back("R10 write same cycle uses old cfg");
    @(posedge clk); #1; cfg_wr = 0; in_valid = 0; c_sh = 4; c_rm = 0; c_en = 1;
    op(1, r16(16'h0011), r16(16'h0001), "R10 new cfg applies next op");
    rdchk("R10 config readback");

    // random
    for (int k = 0; k < 200; k++) begin
      if (k % 10 == 0) begin
        wcfg(1'($urandom), int'($urandom % 8), int'($urandom % 64 > 40 ? $urandom % 64 : $urandom % 20));
      end
      op(1'($urandom), {$urandom, $urandom, $urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom}, "R3 R4 R5 R7 random");
      if (k % 25 == 24) rdchk("R6 R8 random flags");
    end
    idle(4);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results actual %0d pending expected 0", expq.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule